// File: doc/BRIEF.md
# Synchronous Serial Receiver with Sync-Character Hunt

This block turns a synchronous serial bit stream into characters. It samples the data line once per rising edge of the receive bit clock. It does not assemble characters until it has found a character boundary. Framing comes from one of two sources. In internal mode the block slides a window over the stream one bit at a time, looking for one programmed sync character or for a pair of them. In external mode a sync-detect pin, driven from outside, marks the boundary.

Once locked, the block assembles characters of 5 to 8 data bits, least significant bit first. Each character may be followed by a parity bit. Completed characters go into a one-deep receive buffer, which the host drains with a data read. A parity error and an overrun error are reported next to the buffer. A status read clears the sync-detect flag and the overrun flag. A hunt command drops the lock and starts the search again.

The whole block runs on one system clock. The bit clock `rxc` is an input that is edge-detected, so all timing is counted in system clock cycles.

Top module: `sync_rx_top`

## Requirements
- R1: Exactly one data bit is taken per rising edge of `rxc`, from the value on `rxd` at that edge. Changes on `rxd` while `rxc` is steady have no effect.
- R2: After reset or a hunt command in internal mode (`cfg_ext_sync`=0), the receiver hunts. On every bit it compares the newest L bits against the low L bits of `sync_char1`, where L = 5 + `cfg_len` (`cfg_len` 0→5, 1→6, 2→7, 3→8 bits; the oldest bit is the LSB). With `cfg_single_sync`=1 a match locks the receiver at that bit.
- R3: With `cfg_single_sync`=0, a match on `sync_char1` is followed by the next L bits, which are compared with `sync_char2`. An equal character locks the receiver. A different character returns it to bit-by-bit hunting for `sync_char1`.
- R4: In internal mode `syndet_oe` is 1. `syndet_out` rises when internal sync is achieved and stays high until a `rd_status` pulse clears it.
- R5: In external mode, `syndet_oe` is 0 and `syndet_out` stays 0. A high `syndet_in` at a bit edge while hunting locks the receiver. The bit at that edge is not data, and the next bit is the first data bit.
- R6: When locked, each character is L data bits, LSB first. It appears on `rx_data` with the bits above L reading 0, and `rx_ready` becomes 1.
- R7: With `cfg_par_en`=1 each character carries one extra parity bit after its data bits. With `cfg_par_even`=1 the total count of ones must be even, and with `cfg_par_even`=0 it must be odd. `par_err` shows the result for the character now in the buffer.
- R8: If a character completes while `rx_ready` is 1 and no `rd_data` pulse arrives in that cycle, `ovr_err` is set. The new character replaces the buffered one. `ovr_err` stays set until a `rd_status` pulse.
- R9: A `hunt_cmd` pulse drops the lock at once (`hunting`=1). Bits that follow are not assembled until sync is found again.
- R10: A `rd_data` pulse clears `rx_ready`.
- R11: After reset, `rx_ready`, `syndet_out`, `par_err` and `ovr_err` are 0 and `hunting` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxc | input | 1 | Receive bit clock, sampled and edge-detected |
| rxd | input | 1 | Serial data |
| cfg_len | input | 2 | Character length code, L = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_single_sync | input | 1 | 1 one sync character, 0 two |
| cfg_ext_sync | input | 1 | 1 external sync through syndet_in |
| sync_char1 | input | 8 | First sync character |
| sync_char2 | input | 8 | Second sync character |
| syndet_in | input | 1 | External sync level |
| syndet_out | output | 1 | Internal sync-detect flag |
| syndet_oe | output | 1 | Drive enable for the sync-detect pin |
| hunt_cmd | input | 1 | Pulse: re-enter hunting |
| rd_data | input | 1 | Pulse: host reads the receive buffer |
| rd_status | input | 1 | Pulse: host reads status |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity error of buffered character |
| ovr_err | output | 1 | Overrun flag |
| hunting | output | 1 | Receiver has no character framing |

## Verification
A hunt state that locks too early or slides the window wrongly shows up at the ports. `syndet_out` or `hunting` changes at the wrong bit, checked exactly one bit before and at the bit that completes the sync pattern. A bit counter that is off by one shifts every later character, so the first character after sync already comes out on `rx_data` with a wrong value or a missing `rx_ready`. Flag logic with the wrong priority shows in `ovr_err` or `par_err` within three system cycles of the character's last bit.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_LOCK  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sync_rx_edge.sv
module sync_rx_edge (
  input  logic clk,
  input  logic rst,
  input  logic rxc,
  input  logic rxd,
  output logic bit_stb,
  output logic bit_val
);
  logic rxc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxc_q   <= 1'b1;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      rxc_q   <= rxc;
      bit_stb <= rxc & ~rxc_q;
      bit_val <= rxd;
    end
  end

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [CNT_W-1:0]  len,
  output logic [DATA_W-1:0] win_aligned
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;
  logic [CNT_W-1:0]  drop;

  always_comb begin
    sh_next     = {bit_val, sh_q[DATA_W-1:1]};
    drop        = CNT_W'(DATA_W) - len;
    win_aligned = sh_next >> drop;
  end

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (bit_stb) sh_q <= sh_next;
  end
endmodule

// File: rtl/sync_rx_hunt.sv
module sync_rx_hunt
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic [DATA_W-1:0] win_aligned,
  input  logic [CNT_W-1:0]  len,
  input  logic              ext_mode,
  input  logic              single,
  input  logic [DATA_W-1:0] sync1,
  input  logic [DATA_W-1:0] sync2,
  input  logic              ext_level,
  input  logic              hunt_cmd,
  input  logic              rd_status,
  output rx_state_e         state,
  output logic              det_flag
);
  logic [CNT_W-1:0]  sc_q;
  logic [DATA_W-1:0] mask;
  logic              m1, m2, last2, int_lock;
  rx_state_e         nxt;

  always_comb begin
    mask  = {DATA_W{1'b1}} >> (CNT_W'(DATA_W) - len);
    m1    = (win_aligned == (sync1 & mask));
    m2    = (win_aligned == (sync2 & mask));
    last2 = (sc_q == len - CNT_W'(1));
    nxt      = state;
    int_lock = 1'b0;
    if (hunt_cmd) begin
      nxt = ST_HUNT;
    end else if (bit_stb) begin
      case (state)
        ST_HUNT: begin
          if (ext_mode) begin
            if (ext_level) nxt = ST_LOCK;
          end else if (m1) begin
            if (single) begin
              nxt      = ST_LOCK;
              int_lock = 1'b1;
            end else begin
              nxt = ST_SYNC2;
            end
          end
        end
        ST_SYNC2: begin
          if (ext_mode) begin
            nxt = ST_HUNT;
          end else if (last2) begin
            if (m2) begin
              nxt      = ST_LOCK;
              int_lock = 1'b1;
            end else begin
              nxt = ST_HUNT;
            end
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      sc_q     <= '0;
      det_flag <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_SYNC2 && bit_stb && !last2 && !hunt_cmd) sc_q <= sc_q + CNT_W'(1);
      else if (state != ST_SYNC2 || bit_stb || hunt_cmd) sc_q <= '0;
      if (int_lock) det_flag <= 1'b1;
      else if (rd_status) det_flag <= 1'b0;
    end
  end

  // R4
  syndet_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !int_lock) |=> !det_flag);
  // R9
  hunt_enter_chk: assert property (@(posedge clk) disable iff (rst)
    hunt_cmd |=> (state == ST_HUNT));
  // R4
  flag_lock_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(det_flag) |-> (state == ST_LOCK));
endmodule

// File: rtl/sync_rx_asm.sv
module sync_rx_asm #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] win_aligned,
  input  logic [CNT_W-1:0]  len,
  input  logic              locked,
  input  logic              par_en,
  input  logic              par_even,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr
);
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              last_data, par_slot;

  always_comb begin
    last_data = (cnt_q == len - CNT_W'(1));
    par_slot  = (cnt_q == len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      hold_q    <= '0;
      char_done <= 1'b0;
      char_data <= '0;
      char_perr <= 1'b0;
    end else begin
      char_done <= 1'b0;
      if (!locked) begin
        cnt_q <= '0;
      end else if (bit_stb) begin
        if (last_data) begin
          hold_q <= win_aligned;
          if (par_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else begin
            cnt_q     <= '0;
            char_done <= 1'b1;
            char_data <= win_aligned;
            char_perr <= 1'b0;
          end
        end else if (par_slot) begin
          cnt_q     <= '0;
          char_done <= 1'b1;
          char_data <= hold_q;
          char_perr <= (^hold_q) ^ bit_val ^ ~par_even;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DATA_W));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    char_done |=> !char_done);
endmodule

// File: rtl/sync_rx_buf.sv
module sync_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              ovr_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      ovr_err  <= 1'b0;
    end else begin
      if (char_done) begin
        rx_data  <= char_data;
        par_err  <= char_perr;
        rx_ready <= 1'b1;
      end else if (rd_data) begin
        rx_ready <= 1'b0;
      end
      if (char_done && rx_ready && !rd_data) ovr_err <= 1'b1;
      else if (rd_status) ovr_err <= 1'b0;
    end
  end

  // R10
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !char_done) |=> !rx_ready);
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (char_done && rx_ready && !rd_data) |=> ovr_err);
  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (rst)
    char_done |=> rx_ready);
endmodule

// File: rtl/sync_rx_top.sv
module sync_rx_top
  import sync_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxc,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_single_sync,
  input  logic              cfg_ext_sync,
  input  logic [DATA_W-1:0] sync_char1,
  input  logic [DATA_W-1:0] sync_char2,
  input  logic              syndet_in,
  output logic              syndet_out,
  output logic              syndet_oe,
  input  logic              hunt_cmd,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              ovr_err,
  output logic              hunting
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic              bit_stb, bit_val, char_done, char_perr, det_flag;
  logic [CNT_W-1:0]  len;
  logic [DATA_W-1:0] win_aligned, char_data;
  rx_state_e         state;

  assign len = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);

  sync_rx_edge u_edge (
    .clk(clk), .rst(rst), .rxc(rxc), .rxd(rxd),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  sync_rx_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .len(len), .win_aligned(win_aligned)
  );

  sync_rx_hunt #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_hunt (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .win_aligned(win_aligned),
    .len(len), .ext_mode(cfg_ext_sync), .single(cfg_single_sync),
    .sync1(sync_char1), .sync2(sync_char2), .ext_level(syndet_in),
    .hunt_cmd(hunt_cmd), .rd_status(rd_status),
    .state(state), .det_flag(det_flag)
  );

  sync_rx_asm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .win_aligned(win_aligned), .len(len), .locked(state == ST_LOCK),
    .par_en(cfg_par_en), .par_even(cfg_par_even),
    .char_done(char_done), .char_data(char_data), .char_perr(char_perr)
  );

  sync_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
    .char_perr(char_perr), .rd_data(rd_data), .rd_status(rd_status),
    .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err)
  );

  always_ff @(posedge clk) begin
    if (rst) syndet_oe <= 1'b1;
    else     syndet_oe <= ~cfg_ext_sync;
  end

  assign syndet_out = det_flag;
  assign hunting    = (state != ST_LOCK);

  // R9
  done_locked_chk: assert property (@(posedge clk) disable iff (rst)
    char_done |-> ($past(state) == ST_LOCK));
  // R5
  ext_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_ext_sync && $past(cfg_ext_sync) && !$past(det_flag)) |-> !det_flag);
endmodule

// File: tb/sync_rx_top_tb.sv
module sync_rx_top_tb;
  localparam int CLK_PER = 10;

  logic       clk = 0, rst = 1, rxc = 0, rxd = 0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 0, cfg_par_even = 1, cfg_single_sync = 1, cfg_ext_sync = 0;
  logic [7:0] sync_char1 = 8'h16, sync_char2 = 8'h7E;
  logic       syndet_in = 0, hunt_cmd = 0, rd_data = 0, rd_status = 0;
  logic       syndet_out, syndet_oe, rx_ready, par_err, ovr_err, hunting;
  logic [7:0] rx_data;

  int checks = 0, fails = 0, cyc = 0;

  sync_rx_top u_dut (
    .clk(clk), .rst(rst), .rxc(rxc), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_single_sync(cfg_single_sync), .cfg_ext_sync(cfg_ext_sync),
    .sync_char1(sync_char1), .sync_char2(sync_char2), .syndet_in(syndet_in),
    .syndet_out(syndet_out), .syndet_oe(syndet_oe), .hunt_cmd(hunt_cmd),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .rx_ready(rx_ready), .par_err(par_err), .ovr_err(ovr_err), .hunting(hunting)
  );

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); rxd = b; rxc = 0;
    repeat (2) @(negedge clk);
    rxc = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rd_data();
    @(negedge clk); rd_data = 1;
    @(negedge clk); rd_data = 0;
  endtask

  task automatic pulse_status();
    @(negedge clk); rd_status = 1;
    @(negedge clk); rd_status = 0;
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt_cmd = 1;
    @(negedge clk); hunt_cmd = 0;
  endtask

  task automatic t_reset();
    check("R11 rx_ready", rx_ready, 0);
    check("R11 syndet_out", syndet_out, 0);
    check("R11 par_err", par_err, 0);
    check("R11 ovr_err", ovr_err, 0);
    check("R11 hunting", hunting, 1);
    check("R4 syndet_oe internal", syndet_oe, 1);
  endtask

  task automatic t_single();
    send_bits(16'h0007, 3);
    send_bits(16'h0016, 7);
    check("R2 no lock one bit early", syndet_out, 0);
    check("R2 still hunting", hunting, 1);
    send_bits(16'h0000, 1);
    check("R2 lock on last sync bit", syndet_out, 1);
    check("R2 hunting cleared", hunting, 0);
    check("R6 sync not buffered", rx_ready, 0);
    send_bits(16'h00A5, 8);
    check("R6 ready", rx_ready, 1);
    check("R1 R6 data", rx_data, 8'hA5);
    check("R7 no parity error", par_err, 0);
    pulse_status();
    check("R4 status clears syndet", syndet_out, 0);
    check("R10 ready kept by status", rx_ready, 1);
    pulse_rd_data();
    check("R10 read clears ready", rx_ready, 0);
  endtask

  task automatic t_overrun();
    send_bits(16'h0011, 8);
    check("R8 no overrun first", ovr_err, 0);
    send_bits(16'h0022, 8);
    check("R8 overrun set", ovr_err, 1);
    check("R8 newest kept", rx_data, 8'h22);
    pulse_rd_data();
    check("R8 overrun sticky", ovr_err, 1);
    pulse_status();
    check("R8 status clears overrun", ovr_err, 0);
  endtask

  task automatic t_hunt();
    pulse_hunt();
    check("R9 hunting after command", hunting, 1);
    send_bits(16'h00FF, 8);
    check("R9 no char while hunting", rx_ready, 0);
    check("R9 still hunting", hunting, 1);
  endtask

  task automatic t_double();
    cfg_single_sync = 0;
    pulse_hunt();
    send_bits(16'h00FF, 8);
    send_bits(16'h0016, 8);
    check("R3 one sync not enough", syndet_out, 0);
    check("R3 hunting after sync1", hunting, 1);
    send_bits(16'h0000, 8);
    check("R3 mismatch sync2 no lock", syndet_out, 0);
    check("R3 mismatch still hunting", hunting, 1);
    send_bits(16'h0016, 8);
    send_bits(16'h007E, 8);
    check("R3 lock after pair", syndet_out, 1);
    check("R3 locked", hunting, 0);
    send_bits(16'h00C3, 8);
    check("R3 R6 data after pair", rx_data, 8'hC3);
    pulse_rd_data();
    pulse_status();
    cfg_single_sync = 1;
  endtask

  task automatic t_parity();
    cfg_len = 2'd2; cfg_par_en = 1; cfg_par_even = 1;
    pulse_hunt();
    send_bits(16'h007F, 7);
    send_bits(16'h0016, 7);
    check("R2 lock len7", hunting, 0);
    send_bits(16'h0055, 8);
    check("R7 even ok data", rx_data, 8'h55);
    check("R7 even ok flag", par_err, 0);
    pulse_rd_data();
    send_bits(16'h002A, 8);
    check("R7 even bad flag", par_err, 1);
    check("R6 upper bits zero", rx_data, 8'h2A);
    pulse_rd_data();
    cfg_par_even = 0;
    send_bits(16'h0001, 8);
    check("R7 odd ok flag", par_err, 0);
    send_bits(16'h0081, 8);
    check("R7 odd bad flag", par_err, 1);
    pulse_rd_data();
    pulse_status();
    cfg_par_en = 0; cfg_par_even = 1;
  endtask

  task automatic t_len5();
    cfg_len = 2'd0;
    pulse_hunt();
    send_bits(16'h001F, 5);
    send_bits(16'h0016, 5);
    check("R2 lock len5", syndet_out, 1);
    send_bits(16'h000B, 5);
    check("R6 len5 data", rx_data, 8'h0B);
    pulse_rd_data();
    pulse_status();
    cfg_len = 2'd3;
  endtask

  task automatic t_ext();
    cfg_ext_sync = 1;
    pulse_hunt();
    check("R5 syndet_oe external", syndet_oe, 0);
    send_bits(16'h0016, 8);
    check("R5 no sync without level", hunting, 1);
    check("R5 no char without level", rx_ready, 0);
    syndet_in = 1;
    send_bit(1'b1);
    syndet_in = 0;
    send_bits(16'h003C, 8);
    check("R5 first data after level", rx_data, 8'h3C);
    check("R5 ready", rx_ready, 1);
    check("R5 syndet_out low", syndet_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_overrun();
    t_hunt();
    t_double();
    t_parity();
    t_len5();
    t_ext();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule